// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

This block is a 4-bit binary counter driven by two separate count strobes instead of a single clock with a direction pin. A rising edge on the up strobe adds one while the down strobe rests high; a rising edge on the down strobe subtracts one while the up strobe rests high. A level-sensitive clear and an active-low parallel load preset the count at any time. Two active-low terminal-count outputs echo the low phase of the active strobe when the count sits at its top or bottom value. These outputs can drive the strobes of a following stage, so counters chain into wider ones.

The design is fully synchronous to one free-running system clock. Every asynchronous input, including the data word, passes through a two-flop synchronizer. Strobe edges are then found by comparing the synchronized level with its previous value. Each chained stage therefore adds a few system clock cycles of latency.

Top module: `updn_cnt4`

## Requirements
- R1: A rising edge on `up_stb` with `dn_stb` high, and no clear or load active, raises `count` by one.
- R2: A rising edge on `dn_stb` with `up_stb` high, and no clear or load active, lowers `count` by one.
- R3: `tcu_n` is low exactly while `count` is 15 and the synchronized up strobe is low; otherwise it is high.
- R4: `tcd_n` is low exactly while `count` is 0 and the synchronized down strobe is low; otherwise it is high.
- R5: While `clear` is high the count goes to 0, overriding both strobes and any active load.
- R6: While `load_n` is low and `clear` is low, `count` follows `din` regardless of the strobes.
- R7: A strobe held low through a clear or load, and still low after it ends, counts on its next rising edge.
- R8: Counting wraps: up from 15 gives 0, and down from 0 gives 15.
- R9: Rising edges of both strobes seen in the same system clock cycle leave the count unchanged.
- R10: Two stages, with the lower stage's `tcu_n`/`tcd_n` driving the upper stage's `up_stb`/`dn_stb`, form an 8-bit counter that steps correctly in both directions and wraps at 255/0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_stb | input | 1 | Count-up strobe, counts on rising edge |
| dn_stb | input | 1 | Count-down strobe, counts on rising edge |
| load_n | input | 1 | Active-low parallel load |
| clear | input | 1 | Active-high master clear |
| din | input | 4 | Preset data word |
| count | output | 4 | Current count |
| tcu_n | output | 1 | Active-low terminal count at 15 |
| tcd_n | output | 1 | Active-low terminal count at 0 |

## Verification
The bench targets the carry and borrow between chained stages at 15/0 and 0/15. A design with a wrong terminal-count term would leave the upper byte frozen, or step it one pulse early. It holds a strobe low across a clear and a load and then releases it; a design that lost the edge history would miss that count or count twice. It also drives clear and load together, where a wrong priority would leave the preset value in place of zero. Finally, it releases both strobes in the same cycle, where a design without the hold rule would count in one direction.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_INC,
    OP_DEC,
    OP_LOAD,
    OP_CLR
  } cnt_op_e;
endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] meta_d, sync_d;

  always_comb begin
    meta_d = d_async;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      d_sync <= RST_VAL;
    end else begin
      meta_q <= meta_d;
      d_sync <= sync_d;
    end
  end
endmodule

// File: rtl/updn_core.sv
module updn_core
  import updn_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_s,
  input  logic          dn_s,
  input  logic          ld_s_n,
  input  logic          clr_s,
  input  logic [CW-1:0] din_s,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic    up_q, dn_q;
  logic    up_rise, dn_rise;
  cnt_op_e op;
  logic [CW-1:0] cnt_d;
  logic    cnt_en;

  always_comb begin
    up_rise = up_s & ~up_q;
    dn_rise = dn_s & ~dn_q;
  end

  always_comb begin
    if (clr_s)                            op = OP_CLR;
    else if (!ld_s_n)                     op = OP_LOAD;
    else if (up_rise && dn_rise)          op = OP_HOLD;
    else if (up_rise && dn_s)             op = OP_INC;
    else if (dn_rise && up_s)             op = OP_DEC;
    else                                  op = OP_HOLD;
  end

  always_comb begin
    cnt_en = (op != OP_HOLD);
    unique case (op)
      OP_CLR:  cnt_d = '0;
      OP_LOAD: cnt_d = din_s;
      OP_INC:  cnt_d = cnt + 1'b1;
      OP_DEC:  cnt_d = cnt - 1'b1;
      default: cnt_d = cnt;
    endcase
  end

  // Edge history keeps tracking during clear and load (R7)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b1;
      dn_q <= 1'b1;
    end else begin
      up_q <= up_s;
      dn_q <= dn_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && ld_s_n && up_s && !up_q && dn_s && dn_q) |=> (cnt == $past(cnt) + 1'b1));

  a_r2_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && ld_s_n && dn_s && !dn_q && up_s && up_q) |=> (cnt == $past(cnt) - 1'b1));

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (cnt == '0));

  a_r6_load_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && !ld_s_n) |=> (cnt == $past(din_s)));

  a_r8_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && ld_s_n && cnt == CNT_MAX && up_s && !up_q && dn_q) |=> (cnt == '0));

  a_r9_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && ld_s_n && up_s && !up_q && dn_s && !dn_q) |=> $stable(cnt));
endmodule

// File: rtl/updn_term.sv
module updn_term #(
  parameter int CW = 4
) (
  input  logic [CW-1:0] cnt,
  input  logic          up_s,
  input  logic          dn_s,
  output logic          tcu_n,
  output logic          tcd_n
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic at_top, at_bot;

  always_comb begin
    at_top = (cnt == CNT_MAX);
    at_bot = (cnt == '0);
    tcu_n  = ~(at_top & ~up_s);
    tcd_n  = ~(at_bot & ~dn_s);
  end

  always_comb begin
    a_r3_tcu_idle: assert (up_s ? tcu_n : 1'b1);
    a_r4_tcd_idle: assert (dn_s ? tcd_n : 1'b1);
  end
endmodule

// File: rtl/updn_cnt4.sv
module updn_cnt4 #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_stb,
  input  logic          dn_stb,
  input  logic          load_n,
  input  logic          clear,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] count,
  output logic          tcu_n,
  output logic          tcd_n
);
  localparam int SW = CW + 4;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, 1'b1, {CW{1'b0}}};

  logic [SW-1:0] raw_bus, sync_bus;
  logic          clr_s, ld_s_n, dn_s, up_s;
  logic [CW-1:0] din_s;

  always_comb raw_bus = {clear, load_n, dn_stb, up_stb, din};
  always_comb {clr_s, ld_s_n, dn_s, up_s, din_s} = sync_bus;

  updn_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_bus),
    .d_sync  (sync_bus)
  );

  updn_core #(.CW(CW)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_s   (up_s),
    .dn_s   (dn_s),
    .ld_s_n (ld_s_n),
    .clr_s  (clr_s),
    .din_s  (din_s),
    .cnt    (count)
  );

  updn_term #(.CW(CW)) u_term (
    .cnt   (count),
    .up_s  (up_s),
    .dn_s  (dn_s),
    .tcu_n (tcu_n),
    .tcd_n (tcd_n)
  );
endmodule

// File: tb/updn_cnt4_tb.sv
module updn_cnt4_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       up, dn, load_n, clear;
  logic [3:0] din_lo, din_hi;
  logic [3:0] cnt_lo, cnt_hi;
  logic       tcu_lo, tcd_lo, tcu_hi, tcd_hi;
  logic       allow_both;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model;

  always #2.5 clk = ~clk;

  updn_cnt4 u_dut (
    .clk(clk), .rst_n(rst_n), .up_stb(up), .dn_stb(dn), .load_n(load_n),
    .clear(clear), .din(din_lo), .count(cnt_lo), .tcu_n(tcu_lo), .tcd_n(tcd_lo)
  );

  updn_cnt4 u_hi (
    .clk(clk), .rst_n(rst_n), .up_stb(tcu_lo), .dn_stb(tcd_lo), .load_n(load_n),
    .clear(clear), .din(din_hi), .count(cnt_hi), .tcu_n(tcu_hi), .tcd_n(tcd_hi)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] step_up(input logic [7:0] v);
    return v + 8'd1;
  endfunction

  function automatic logic [7:0] step_dn(input logic [7:0] v);
    return v - 8'd1;
  endfunction

  function automatic logic exp_tc(input logic [3:0] c, input logic [3:0] lim);
    return (c == lim) ? 1'b0 : 1'b1;
  endfunction

  always @(negedge clk)
    if (rst_n && !up && !dn && !allow_both)
      $display("NOTE: unsupported condition, both strobes low");

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_up();
    up = 1'b0;
    wait_n(5);
    chk("R3 tcu_n during up low", {7'd0, tcu_lo}, {7'd0, exp_tc(model[3:0], 4'hF)});
    up = 1'b1;
    wait_n(12);
    model = step_up(model);
    chk("R1/R8/R10 up count", {cnt_hi, cnt_lo}, model);
  endtask

  task automatic pulse_dn();
    dn = 1'b0;
    wait_n(5);
    chk("R4 tcd_n during down low", {7'd0, tcd_lo}, {7'd0, exp_tc(model[3:0], 4'h0)});
    dn = 1'b1;
    wait_n(12);
    model = step_dn(model);
    chk("R2/R8/R10 down count", {cnt_hi, cnt_lo}, model);
  endtask

  task automatic do_load(input logic [7:0] v);
    {din_hi, din_lo} = v;
    load_n = 1'b0;
    wait_n(5);
    load_n = 1'b1;
    wait_n(5);
    model = v;
    chk("R6 load", {cnt_hi, cnt_lo}, model);
  endtask

  task automatic do_clear();
    clear = 1'b1;
    wait_n(5);
    clear = 1'b0;
    wait_n(5);
    model = 8'd0;
    chk("R5 clear", {cnt_hi, cnt_lo}, model);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned r;
    rst_n = 1'b0; up = 1'b1; dn = 1'b1; load_n = 1'b1; clear = 1'b0;
    din_lo = 4'h0; din_hi = 4'h0; allow_both = 1'b0;
    model = 8'd0;
    void'($urandom(32'd1193));
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    chk("reset count", {cnt_hi, cnt_lo}, 8'h00);
    chk("reset R3/R4 tc", {4'd0, tcu_lo, tcd_lo, tcu_hi, tcd_hi}, 8'h0F);

    // R8 / R10 carry across 15 -> 16 and wrap at 255
    do_load(8'h0E);
    pulse_up(); pulse_up(); pulse_up();
    do_load(8'hFE);
    pulse_up(); pulse_up();
    // R8 / R10 borrow 0 -> 255 and 16 -> 15
    pulse_dn(); pulse_dn();
    do_load(8'h11);
    pulse_dn(); pulse_dn(); pulse_dn();

    // R5: clear overrides a simultaneous load
    {din_hi, din_lo} = 8'hA5;
    load_n = 1'b0; clear = 1'b1;
    wait_n(5);
    load_n = 1'b1; clear = 1'b0;
    wait_n(5);
    model = 8'd0;
    chk("R5 clear beats load", {cnt_hi, cnt_lo}, model);

    // R7: up held low through clear, counts when released
    up = 1'b0;
    wait_n(3);
    clear = 1'b1; wait_n(5); clear = 1'b0; wait_n(5);
    up = 1'b1; wait_n(12);
    chk("R7 up after clear", {cnt_hi, cnt_lo}, 8'h01);

    // R7: down held low through load, counts when released
    dn = 1'b0;
    wait_n(3);
    {din_hi, din_lo} = 8'h03;
    load_n = 1'b0; wait_n(5); load_n = 1'b1; wait_n(5);
    dn = 1'b1; wait_n(12);
    chk("R7 down after load", {cnt_hi, cnt_lo}, 8'h02);
    model = 8'h02;

    // R9: both strobes released in the same cycle hold the count
    do_load(8'h35);
    allow_both = 1'b1;
    up = 1'b0; dn = 1'b0; wait_n(5);
    up = 1'b1; dn = 1'b1; wait_n(12);
    allow_both = 1'b0;
    chk("R9 both edges hold", {cnt_hi, cnt_lo}, model);

    // Constrained random mix
    for (int k = 0; k < 160; k++) begin
      r = $urandom % 12;
      if (r < 5)       pulse_up();
      else if (r < 10) pulse_dn();
      else if (r == 10) do_load(8'($urandom));
      else              do_clear();
    end

    finish_run();
  end
endmodule